// File: doc/BRIEF.md
# Multi-Port GPIO Register Controller

This block holds the configuration registers for eight general-purpose I/O ports and turns them into per-pad controls. For each pin it produces an output enable (tri-state control), an output value and a weak pull-up enable. It also gates the incoming pad level through the pin's input enable. A pin can be given to an alternate on-chip device, which then supplies the pin's output value and direction and receives the pin's input level.

Software reaches the registers through a small synchronous bus. Each port has its own feature set. One port is input-only. Three ports have no pull-up. One port takes its alternate-function choice from a strap sampled at power-up instead of from a register. One port carries hardwired and preset bits. One port keeps its contents across a warm reset and is cleared only by a power-up or watchdog reset.

All 52 pins sit in one flat vector. Ports A to H occupy bit offsets 0, 7, 15, 23, 31, 33, 41 and 46, and their widths are 7, 8, 8, 8, 2, 8, 5 and 6.

Top module: `gpio_bank`

## Requirements
- R1: The register address is {port[2:0], reg[2:0]}, with ports A..H numbered 0..7. The reg codes are: 0 data-out, 1 direction, 2 alternate select, 3 pull-up, 4 data-in (read-only). A write with `bus_we`=1 takes effect at the next rising clock. `bus_rdata` reflects the register selected by `bus_addr` combinationally. Bits above a port's width, reg codes 5..7 and absent registers read 0, and writes to them are ignored.
- R2: When a pin's alternate select is 0, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its data-out bit.
- R3: When a pin's alternate select is 1, `pad_oe` follows `alt_dir`, `pad_out` follows `alt_out`, and `alt_in` carries the gated pad level. When the select is 0, `alt_in` is 0.
- R4: Port A (7 bits) has no alternate-select register: it reads 0 and ignores writes. Its per-pin alternate select is `strap_a_alt`, sampled on every clock while `por_n` is low and held otherwise.
- R5: Port B bit 6 alternate select always reads 1 and ignores writes, so that pin is always driven by the alternate device.
- R6: Port B bit 5 alternate select always reads 0. After any reset that clears port B, the direction and data-out bits of port B bit 5 are both 1, so the pin drives high.
- R7: Port C registers are cleared only when `por_n` or `wdt_n` is low at a clock edge. A low `warm_n` leaves them unchanged.
- R8: Port D is input-only. Its `pad_oe`, `pad_out` and `pad_pu` bits are always 0, and its reg codes 0..3 read 0.
- R9: Ports F, G and H have no pull-up. Their reg code 3 reads 0, and their `pad_pu` bits stay 0. On ports A, B, C and E, `pad_pu` equals the pull-up bit.
- R10: When a pin's `in_en` is 0, its data-in read bit and its `alt_in` bit are 0, whatever the pad level.
- R11: Reset is synchronous and active low. While any of `por_n`, `wdt_n` or `warm_n` is low, every register outside port C is held at its reset value. That value is 0, except for the port B bit 5 and bit 6 presets.
- R12: Open-drain emulation works as follows. With data-out at 0 and alternate select at 0, direction 1 gives `pad_oe`=1 with `pad_out`=0, and direction 0 gives `pad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, synchronous |
| wdt_n | input | 1 | Watchdog reset, active low, synchronous |
| warm_n | input | 1 | Warm reset, active low, synchronous |
| bus_addr | input | 6 | Register address {port, reg} |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| strap_a_alt | input | 7 | Port A alternate-select strap |
| pad_in | input | 52 | Pad input levels |
| in_en | input | 52 | Per-pin input buffer enable |
| pad_oe | output | 52 | Per-pin output enable |
| pad_out | output | 52 | Per-pin output value |
| pad_pu | output | 52 | Per-pin weak pull-up enable |
| alt_out | input | 52 | Alternate device output data |
| alt_dir | input | 52 | Alternate device direction (1 = output) |
| alt_in | output | 52 | Gated pad level routed to the alternate device |

## Verification
The assertions check the following on every clock:
- a bus write to a data-out register lands one cycle later;
- the hardwired bits of port B's alternate register read correctly;
- port C holds its contents during a warm reset;
- a write to a pull-up register of a port without pull-ups never reaches a pad;
- disabled inputs never reach the alternate device.

The bench's reference model covers the rest across mixed traffic. This includes strap sampling, the preset of port B bit 5 after each reset kind, and the separation of the power-up and watchdog domain from the warm one. It also includes the open-drain sequence, which only ordered scenarios can show.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int NPORT      = 8;
   localparam int REG_SEL_W  = 3;
   localparam int PORT_SEL_W = $clog2(NPORT);

   localparam int PORT_A = 0;
   localparam int PORT_B = 1;
   localparam int PORT_C = 2;
   localparam int PORT_D = 3;
   localparam int PORT_E = 4;
   localparam int PORT_F = 5;
   localparam int PORT_G = 6;
   localparam int PORT_H = 7;

   localparam int STRAP_PORT = PORT_A;

   typedef enum logic [REG_SEL_W-1:0] {
      RG_DOUT = 3'd0,
      RG_DIR  = 3'd1,
      RG_ALT  = 3'd2,
      RG_PU   = 3'd3,
      RG_DIN  = 3'd4
   } reg_sel_e;

   function automatic int port_w(input int p);
      case (p)
         PORT_A:  return 7;
         PORT_B:  return 8;
         PORT_C:  return 8;
         PORT_D:  return 8;
         PORT_E:  return 2;
         PORT_F:  return 8;
         PORT_G:  return 5;
         PORT_H:  return 6;
         default: return 0;
      endcase
   endfunction

   function automatic int port_off(input int p);
      int acc;
      acc = 0;
      for (int i = 0; i < p; i++) acc += port_w(i);
      return acc;
   endfunction

   localparam int NPIN    = port_off(NPORT);
   localparam int STRAP_W = port_w(STRAP_PORT);

   function automatic bit has_out(input int p);
      return p != PORT_D;
   endfunction

   function automatic bit has_alt_reg(input int p);
      return (p != PORT_D) && (p != STRAP_PORT);
   endfunction

   function automatic bit has_pu(input int p);
      return (p == PORT_A) || (p == PORT_B) || (p == PORT_C) || (p == PORT_E);
   endfunction

   function automatic bit cold_only(input int p);
      return p == PORT_C;
   endfunction

   function automatic logic [7:0] alt_one(input int p);
      return (p == PORT_B) ? 8'h40 : 8'h00;
   endfunction

   function automatic logic [7:0] alt_zero(input int p);
      return (p == PORT_B) ? 8'h20 : 8'h00;
   endfunction

   function automatic logic [7:0] rst_drive(input int p);
      return (p == PORT_B) ? 8'h20 : 8'h00;
   endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_bank_pkg::*;
#(
   parameter int         W        = 8,
   parameter bit         HAS_OUT  = 1'b1,
   parameter bit         HAS_ALT  = 1'b1,
   parameter bit         HAS_PU   = 1'b1,
   parameter logic [7:0] ALT_ONE  = 8'h00,
   parameter logic [7:0] ALT_ZERO = 8'h00,
   parameter logic [7:0] RST_DIR  = 8'h00,
   parameter logic [7:0] RST_DOUT = 8'h00
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_SEL_W-1:0] reg_sel,
   input  logic [W-1:0]         wdata,
   output logic [W-1:0]         dout_q,
   output logic [W-1:0]         dir_q,
   output logic [W-1:0]         alt_q,
   output logic [W-1:0]         pu_q
);

   localparam logic [W-1:0] ONE_M  = ALT_ONE[W-1:0];
   localparam logic [W-1:0] ZERO_M = ALT_ZERO[W-1:0];

   if (W < 1 || W > 8) begin : g_chk_w
      $error("gpio_port_regs: width out of range");
   end
   if ((ALT_ONE & ALT_ZERO) != 8'h00) begin : g_chk_mask
      $error("gpio_port_regs: a bit cannot be hardwired both ways");
   end

   if (HAS_OUT) begin : g_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dout_q <= RST_DOUT[W-1:0];
            dir_q  <= RST_DIR[W-1:0];
         end else if (wr_en) begin
            if (reg_sel == RG_DOUT) dout_q <= wdata;
            if (reg_sel == RG_DIR)  dir_q  <= wdata;
         end
      end

      // R1: a data-out write is visible one cycle later
      a_r1_dout_write: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && reg_sel == RG_DOUT) |=> (dout_q == $past(wdata)));
   end else begin : g_no_out
      assign dout_q = '0;
      assign dir_q  = '0;
   end

   if (HAS_ALT) begin : g_alt
      logic [W-1:0] alt_r;
      always_ff @(posedge clk) begin
         if (!rst_n)                              alt_r <= '0;
         else if (wr_en && reg_sel == RG_ALT)     alt_r <= wdata;
      end
      assign alt_q = (alt_r & ~ZERO_M) | ONE_M;
   end else begin : g_no_alt
      assign alt_q = '0;
   end

   if (HAS_PU) begin : g_pu
      always_ff @(posedge clk) begin
         if (!rst_n)                              pu_q <= '0;
         else if (wr_en && reg_sel == RG_PU)      pu_q <= wdata;
      end
   end else begin : g_no_pu
      assign pu_q = '0;
   end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int W       = 8,
   parameter bit HAS_OUT = 1'b1,
   parameter bit HAS_PU  = 1'b1
)(
   input  logic [W-1:0] sel,
   input  logic [W-1:0] dout,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] pu,
   input  logic [W-1:0] alt_out,
   input  logic [W-1:0] alt_dir,
   input  logic [W-1:0] pad_in,
   input  logic [W-1:0] in_en,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_pu,
   output logic [W-1:0] din,
   output logic [W-1:0] alt_in
);

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign din[b]    = in_en[b] & pad_in[b];
      assign alt_in[b] = sel[b] & din[b];

      if (HAS_OUT) begin : g_drv
         assign pad_oe[b]  = sel[b] ? alt_dir[b] : dir[b];
         assign pad_out[b] = sel[b] ? alt_out[b] : dout[b];
      end else begin : g_nodrv
         assign pad_oe[b]  = 1'b0;
         assign pad_out[b] = 1'b0;
      end

      if (HAS_PU) begin : g_pull
         assign pad_pu[b] = pu[b];
      end else begin : g_nopull
         assign pad_pu[b] = 1'b0;
      end
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
)(
   input  logic               clk,
   input  logic               por_n,
   input  logic               wdt_n,
   input  logic               warm_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [STRAP_W-1:0] strap_a_alt,
   input  logic [NPIN-1:0]    pad_in,
   input  logic [NPIN-1:0]    in_en,
   output logic [NPIN-1:0]    pad_oe,
   output logic [NPIN-1:0]    pad_out,
   output logic [NPIN-1:0]    pad_pu,
   input  logic [NPIN-1:0]    alt_out,
   input  logic [NPIN-1:0]    alt_dir,
   output logic [NPIN-1:0]    alt_in
);

   if (ADDR_W != PORT_SEL_W + REG_SEL_W) begin : g_chk_addr
      $error("gpio_bank: address width must be port bits plus reg bits");
   end

   logic cold_n;
   logic any_n;
   assign cold_n = por_n & wdt_n;
   assign any_n  = cold_n & warm_n;

   logic [PORT_SEL_W-1:0] acc_port;
   logic [REG_SEL_W-1:0]  acc_reg;
   assign acc_port = bus_addr[ADDR_W-1:REG_SEL_W];
   assign acc_reg  = bus_addr[REG_SEL_W-1:0];

   logic [STRAP_W-1:0] strap_q;
   always_ff @(posedge clk) begin
      if (!por_n) strap_q <= strap_a_alt;
   end

   logic [DATA_W-1:0] v_dout [NPORT];
   logic [DATA_W-1:0] v_dir  [NPORT];
   logic [DATA_W-1:0] v_alt  [NPORT];
   logic [DATA_W-1:0] v_pu   [NPORT];
   logic [DATA_W-1:0] v_din  [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam int PW  = port_w(p);
      localparam int OFF = port_off(p);

      if (PW > DATA_W) begin : g_chk_pw
         $error("gpio_bank: port wider than the data bus");
      end

      logic          rst_n;
      logic          wr_en;
      logic [PW-1:0] dout_q, dir_q, alt_q, pu_q, din, sel;

      assign rst_n = cold_only(p) ? cold_n : any_n;
      assign wr_en = bus_we && (acc_port == PORT_SEL_W'(p));

      gpio_port_regs #(
         .W        (PW),
         .HAS_OUT  (has_out(p)),
         .HAS_ALT  (has_alt_reg(p)),
         .HAS_PU   (has_pu(p)),
         .ALT_ONE  (alt_one(p)),
         .ALT_ZERO (alt_zero(p)),
         .RST_DIR  (rst_drive(p)),
         .RST_DOUT (rst_drive(p))
      ) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .reg_sel (acc_reg),
         .wdata   (bus_wdata[PW-1:0]),
         .dout_q  (dout_q),
         .dir_q   (dir_q),
         .alt_q   (alt_q),
         .pu_q    (pu_q)
      );

      if (p == STRAP_PORT) begin : g_strap_sel
         assign sel = strap_q;
      end else begin : g_reg_sel
         assign sel = alt_q;
      end

      gpio_pad_mux #(
         .W       (PW),
         .HAS_OUT (has_out(p)),
         .HAS_PU  (has_pu(p))
      ) u_mux (
         .sel     (sel),
         .dout    (dout_q),
         .dir     (dir_q),
         .pu      (pu_q),
         .alt_out (alt_out[OFF +: PW]),
         .alt_dir (alt_dir[OFF +: PW]),
         .pad_in  (pad_in[OFF +: PW]),
         .in_en   (in_en[OFF +: PW]),
         .pad_oe  (pad_oe[OFF +: PW]),
         .pad_out (pad_out[OFF +: PW]),
         .pad_pu  (pad_pu[OFF +: PW]),
         .din     (din),
         .alt_in  (alt_in[OFF +: PW])
      );

      assign v_dout[p] = DATA_W'(dout_q);
      assign v_dir[p]  = DATA_W'(dir_q);
      assign v_alt[p]  = DATA_W'(alt_q);
      assign v_pu[p]   = DATA_W'(pu_q);
      assign v_din[p]  = DATA_W'(din);
   end

   always_comb begin
      case (acc_reg)
         RG_DOUT: bus_rdata = v_dout[acc_port];
         RG_DIR:  bus_rdata = v_dir[acc_port];
         RG_ALT:  bus_rdata = v_alt[acc_port];
         RG_PU:   bus_rdata = v_pu[acc_port];
         RG_DIN:  bus_rdata = v_din[acc_port];
         default: bus_rdata = '0;
      endcase
   end

   localparam logic [ADDR_W-1:0] B_ALT_ADDR = {PORT_SEL_W'(PORT_B), RG_ALT};
   localparam logic [ADDR_W-1:0] F_PU_ADDR  = {PORT_SEL_W'(PORT_F), RG_PU};
   localparam int OFF_F  = port_off(PORT_F);
   localparam int NOPU_W = NPIN - OFF_F;

   // R5: port B bit 6 alternate select reads as 1
   a_r5_b6_alt_one: assert property (@(posedge clk) disable iff (!any_n)
      (bus_addr == B_ALT_ADDR) |-> bus_rdata[6]);

   // R6: port B bit 5 alternate select reads as 0
   a_r6_b5_alt_zero: assert property (@(posedge clk) disable iff (!any_n)
      (bus_addr == B_ALT_ADDR) |-> !bus_rdata[5]);

   // R7: warm reset leaves port C untouched
   a_r7_warm_keeps_c: assert property (@(posedge clk) disable iff (!cold_n)
      (!warm_n && !(bus_we && acc_port == PORT_SEL_W'(PORT_C)))
      |=> ($stable(v_dout[PORT_C]) && $stable(v_dir[PORT_C])
           && $stable(v_alt[PORT_C]) && $stable(v_pu[PORT_C])));

   // R9: pull-up writes on ports without pull-ups never reach the pads
   a_r9_no_pu_pads: assert property (@(posedge clk) disable iff (!any_n)
      (bus_we && bus_addr == F_PU_ADDR) |=> (pad_pu[OFF_F +: NOPU_W] == '0));

   // R10: disabled inputs never reach the alternate device
   a_r10_gate_alt: assert property (@(posedge clk) disable iff (!any_n)
      (in_en == '0) |-> (alt_in == '0));

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

   localparam int PERIOD = 10;
   localparam int NP     = 52;

   logic          clk = 1'b0;
   logic          por_n, wdt_n, warm_n;
   logic [5:0]    bus_addr;
   logic          bus_we;
   logic [7:0]    bus_wdata;
   logic [7:0]    bus_rdata;
   logic [6:0]    strap_a_alt;
   logic [NP-1:0] pad_in, in_en, pad_oe, pad_out, pad_pu, alt_out, alt_dir, alt_in;

   int compared   = 0;
   int mismatched = 0;
   bit started    = 0;

   gpio_bank uut (
      .clk(clk), .por_n(por_n), .wdt_n(wdt_n), .warm_n(warm_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .strap_a_alt(strap_a_alt),
      .pad_in(pad_in), .in_en(in_en), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pu(pad_pu), .alt_out(alt_out), .alt_dir(alt_dir), .alt_in(alt_in)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference model
   int         wid [8] = '{7, 8, 8, 8, 2, 8, 5, 6};
   logic [7:0] m_dout [8];
   logic [7:0] m_dir  [8];
   logic [7:0] m_alt  [8];
   logic [7:0] m_pu   [8];
   logic [6:0] m_strap;

   function automatic int offs(input int p);
      int s = 0;
      for (int i = 0; i < p; i++) s += wid[i];
      return s;
   endfunction
   function automatic bit can_out(input int p); return p != 3; endfunction
   function automatic bit can_alt(input int p); return p != 3 && p != 0; endfunction
   function automatic bit can_pu(input int p);  return p == 0 || p == 1 || p == 2 || p == 4; endfunction
   function automatic logic [7:0] wmask(input int p); return 8'((1 << wid[p]) - 1); endfunction

   task automatic model_reset(input int p);
      m_dout[p] = (p == 1) ? 8'h20 : 8'h00;
      m_dir[p]  = (p == 1) ? 8'h20 : 8'h00;
      m_alt[p]  = (p == 1) ? 8'h40 : 8'h00;
      m_pu[p]   = 8'h00;
   endtask

   always @(posedge clk) begin
      bit cold, anyr, rp;
      int wp, wr;
      started = 1;
      cold = !por_n || !wdt_n;
      anyr = cold || !warm_n;
      if (!por_n) m_strap = strap_a_alt;
      wp = int'(bus_addr[5:3]);
      wr = int'(bus_addr[2:0]);
      for (int p = 0; p < 8; p++) begin
         rp = (p == 2) ? cold : anyr;
         if (rp) model_reset(p);
         else if (bus_we && wp == p) begin
            case (wr)
               0: if (can_out(p)) m_dout[p] = bus_wdata & wmask(p);
               1: if (can_out(p)) m_dir[p]  = bus_wdata & wmask(p);
               2: if (can_alt(p)) m_alt[p]  = (p == 1) ? ((bus_wdata & 8'h9F) | 8'h40)
                                                        : (bus_wdata & wmask(p));
               3: if (can_pu(p))  m_pu[p]   = bus_wdata & wmask(p);
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      logic [NP-1:0] e_oe, e_out, e_pu, e_ain;
      logic [7:0] e_din [8];
      logic [7:0] e_rd;
      if (started) begin
         for (int p = 0; p < 8; p++) begin
            e_din[p] = 8'h00;
            for (int b = 0; b < wid[p]; b++) begin
               int  i;
               bit  s, g;
               i = offs(p) + b;
               s = (p == 0) ? m_strap[b] : (can_alt(p) ? m_alt[p][b] : 1'b0);
               g = in_en[i] & pad_in[i];
               e_din[p][b] = g;
               e_oe[i]  = can_out(p) ? (s ? alt_dir[i] : m_dir[p][b]) : 1'b0;
               e_out[i] = can_out(p) ? (s ? alt_out[i] : m_dout[p][b]) : 1'b0;
               e_pu[i]  = can_pu(p) ? m_pu[p][b] : 1'b0;
               e_ain[i] = s & g;
            end
         end
         case (int'(bus_addr[2:0]))
            0: e_rd = m_dout[bus_addr[5:3]];
            1: e_rd = m_dir[bus_addr[5:3]];
            2: e_rd = m_alt[bus_addr[5:3]];
            3: e_rd = m_pu[bus_addr[5:3]];
            4: e_rd = e_din[bus_addr[5:3]];
            default: e_rd = 8'h00;
         endcase
         chk(pad_oe  === e_oe,  "R2/R3", "pad_oe",    64'(pad_oe),    64'(e_oe));
         chk(pad_out === e_out, "R2/R3", "pad_out",   64'(pad_out),   64'(e_out));
         chk(pad_pu  === e_pu,  "R9",    "pad_pu",    64'(pad_pu),    64'(e_pu));
         chk(alt_in  === e_ain, "R3/R10","alt_in",    64'(alt_in),    64'(e_ain));
         chk(bus_rdata === e_rd,"R1",    "bus_rdata", 64'(bus_rdata), 64'(e_rd));
      end
   end

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic settle;
      @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(PERIOD * 200000);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      por_n = 0; wdt_n = 1; warm_n = 1;
      bus_addr = '0; bus_we = 0; bus_wdata = '0;
      strap_a_alt = 7'h55;
      pad_in = '0; in_en = '1; alt_out = '0; alt_dir = '0;
      repeat (3) @(posedge clk);
      #1 por_n = 1;

      // R11 / R6 / R5 reset values
      rd({3'd1, 3'd1}, v); chk(v == 8'h20, "R6", "B dir reset",  v, 8'h20);
      rd({3'd1, 3'd0}, v); chk(v == 8'h20, "R6", "B dout reset", v, 8'h20);
      rd({3'd1, 3'd2}, v); chk(v == 8'h40, "R5", "B alt reset",  v, 8'h40);
      rd({3'd5, 3'd1}, v); chk(v == 8'h00, "R11", "F dir reset", v, 8'h00);
      settle(); chk(pad_oe[12] && pad_out[12], "R6", "B5 drives high", 64'({pad_oe[12], pad_out[12]}), 64'h3);

      // R4 strap-selected alternate on port A
      #1 alt_dir = '1; alt_out = '1;
      settle(); chk(pad_oe[6:0] == 7'h55, "R4", "A oe from strap", 64'(pad_oe[6:0]), 64'h55);
      wr({3'd0, 3'd2}, 8'h7F);
      rd({3'd0, 3'd2}, v); chk(v == 8'h00, "R4", "A alt absent", v, 8'h00);

      // R5 hardwired bits of port B alt
      wr({3'd1, 3'd2}, 8'h00);
      rd({3'd1, 3'd2}, v); chk(v == 8'h40, "R5", "B alt write 0", v, 8'h40);
      wr({3'd1, 3'd2}, 8'hFF);
      rd({3'd1, 3'd2}, v); chk(v == 8'hDF, "R6", "B alt write FF", v, 8'hDF);

      // R12 open drain on port E bit 0
      wr({3'd4, 3'd0}, 8'h00);
      wr({3'd4, 3'd1}, 8'h01);
      settle(); chk(pad_oe[31] && !pad_out[31], "R12", "E0 drives low", 64'({pad_oe[31], pad_out[31]}), 64'h2);
      wr({3'd4, 3'd1}, 8'h00);
      settle(); chk(!pad_oe[31], "R12", "E0 released", 64'(pad_oe[31]), 64'h0);

      // R2 GPIO drive on port F
      wr({3'd5, 3'd0}, 8'h3C);
      wr({3'd5, 3'd2}, 8'h00);
      wr({3'd5, 3'd1}, 8'hFF);
      settle(); chk(pad_out[40:33] == 8'h3C, "R2", "F out", 64'(pad_out[40:33]), 64'h3C);
      chk(pad_oe[40:33] == 8'hFF, "R2", "F oe", 64'(pad_oe[40:33]), 64'hFF);

      // R3 alternate device on low nibble of port F
      #1 pad_in[40:33] = 8'hA5;
      wr({3'd5, 3'd2}, 8'h0F);
      settle(); chk(pad_out[40:33] == 8'h3F, "R3", "F mixed out", 64'(pad_out[40:33]), 64'h3F);
      chk(alt_in[40:33] == 8'h05, "R3", "F alt_in", 64'(alt_in[40:33]), 64'h05);

      // R10 input gating
      #1 in_en[40:33] = '0;
      rd({3'd5, 3'd4}, v); chk(v == 8'h00, "R10", "F din gated", v, 8'h00);
      chk(alt_in[40:33] == 8'h00, "R10", "F alt_in gated", 64'(alt_in[40:33]), 64'h0);
      #1 in_en = '1;

      // R9 pull-ups
      wr({3'd5, 3'd3}, 8'hFF);
      rd({3'd5, 3'd3}, v); chk(v == 8'h00, "R9", "F pu absent", v, 8'h00);
      chk(pad_pu[40:33] == 8'h00, "R9", "F pad_pu", 64'(pad_pu[40:33]), 64'h0);
      wr({3'd0, 3'd3}, 8'h7F);
      settle(); chk(pad_pu[6:0] == 7'h7F, "R9", "A pad_pu", 64'(pad_pu[6:0]), 64'h7F);

      // R8 input-only port D
      for (int r = 0; r < 4; r++) wr({3'd3, 3'(r)}, 8'hFF);
      for (int r = 0; r < 4; r++) begin
         rd({3'd3, 3'(r)}, v); chk(v == 8'h00, "R8", "D reg absent", v, 8'h00);
      end
      chk(pad_oe[30:23] == 8'h00, "R8", "D never drives", 64'(pad_oe[30:23]), 64'h0);
      #1 pad_in[30:23] = 8'h96;
      rd({3'd3, 3'd4}, v); chk(v == 8'h96, "R8", "D din", v, 8'h96);

      // R1 unimplemented code and width clipping
      rd({3'd0, 3'd5}, v); chk(v == 8'h00, "R1", "code 5", v, 8'h00);
      #1 pad_in = '1;
      rd({3'd6, 3'd4}, v); chk(v == 8'h1F, "R1", "G din width", v, 8'h1F);

      // R7 warm reset keeps port C, watchdog clears it
      wr({3'd2, 3'd0}, 8'hA5);
      @(posedge clk); #1 warm_n = 0;
      repeat (2) @(posedge clk); #1 warm_n = 1;
      rd({3'd2, 3'd0}, v); chk(v == 8'hA5, "R7", "C kept on warm", v, 8'hA5);
      rd({3'd5, 3'd0}, v); chk(v == 8'h00, "R11", "F cleared on warm", v, 8'h00);
      @(posedge clk); #1 wdt_n = 0;
      @(posedge clk); #1 wdt_n = 1;
      rd({3'd2, 3'd0}, v); chk(v == 8'h00, "R7", "C cleared on watchdog", v, 8'h00);

      // mixed random traffic, compared every cycle
      for (int n = 0; n < 4000; n++) begin
         @(posedge clk); #1;
         bus_addr  = 6'($urandom);
         bus_we    = ($urandom % 3) == 0;
         bus_wdata = 8'($urandom);
         pad_in    = {20'($urandom), 32'($urandom)};
         in_en     = {20'($urandom), 32'($urandom)} | {20'($urandom), 32'($urandom)};
         alt_out   = {20'($urandom), 32'($urandom)};
         alt_dir   = {20'($urandom), 32'($urandom)};
         strap_a_alt = 7'($urandom);
         warm_n    = ($urandom % 150) != 0;
         wdt_n     = ($urandom % 400) != 0;
         por_n     = ($urandom % 700) != 0;
      end
      @(posedge clk); #1;
      bus_we = 0; warm_n = 1; wdt_n = 1; por_n = 1;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule